// File: doc/BRIEF.md
# Transmit FIFO Empty-Threshold Interrupt and DMA Request Generator

This block holds outgoing bytes in a short queue between a host and a serial shifter. The host writes bytes in through a push port, and the shifter takes them out through a pop port. The block watches the fill level. It drives a level-sensitive transmit-empty interrupt, a wait/request line and an alternate request line. Each of these fires on one of two thresholds. The first is "a slot is free at the entry". The second is "the queue is completely empty". A bit in a small configuration register picks which one applies.

The alternate request line normally releases after a fixed hold of several clocks. A timing bit can switch it so that it releases in the same cycle as the wait/request line. A host read port returns a status word. It can also return the configuration register itself, but only when the read-back bit is set. A synchronous reset and a separate channel reset both clear the configuration, which puts every feature back to its legacy setting.

Top module: `txfifo_req_gen`

## Requirements
- R1: After `rst`, the configuration is zero, the queue is empty and the status word reads 0x20. `irq` reads 1 one cycle after reset is released, and `wreq` and `alt_req` read 0.
- R2: Accepted bytes leave in the order they arrived. `pop_data` updates on the clock edge that samples `pop_req`. The queue holds DEPTH (4) bytes. Status bits are: bit 7 overflow, bit 6 full, bit 5 empty, bits 2:0 count.
- R3: A push while the queue holds DEPTH bytes is dropped. This holds even when a pop happens in the same cycle. The push also sets the sticky overflow flag (status bit 7).
- R4: A pop from an empty queue leaves `pop_data` at the last byte delivered and changes neither the count nor any flag.
- R5: When config bit 0 (empty threshold) is 0, `irq` is 1 exactly when the count is below DEPTH. It is registered one cycle behind the count.
- R6: When config bit 0 is 1, `irq` is 1 exactly when the count is 0. It is registered one cycle behind the count.
- R7: `wreq` is 1 only while config bit 3 (request enable) is 1, and then it follows the same threshold and timing as `irq`.
- R8: With config bit 4 (alternate enable) set and config bit 1 (fast release) clear, `alt_req` asserts in the same cycle as `wreq` would. It falls REL_DELAY (4) cycles after the threshold condition would have released it.
- R9: With config bit 1 set, `alt_req` falls in the same cycle as the threshold release, together with `wreq`.
- R10: Config bits 7:5 are reserved. Writes to them are ignored, and they read back as 0.
- R11: Reads are registered, so `rd_data` is valid one cycle after `rd_addr`. Address 0 returns status. Address 14 returns the configuration when config bit 2 (read-back enable) is 1, and returns status otherwise. Every other address returns 0.
- R12: `chan_rst` clears the configuration, the queue and the overflow flag, in the same way as `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| chan_rst | input | 1 | Synchronous active-high channel reset |
| push_valid | input | 1 | Host pushes `push_data` this cycle |
| push_data | input | DATA_W | Byte to queue |
| pop_req | input | 1 | Shifter takes one byte this cycle |
| pop_data | output | DATA_W | Byte taken, registered |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | DATA_W | Configuration value |
| rd_addr | input | RADDR_W | Host read address |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Level transmit-empty interrupt |
| wreq | output | 1 | Wait/request line |
| alt_req | output | 1 | Alternate request line |

## Verification
The bench builds the block with its default parameters: DEPTH 4, REL_DELAY 4, 8-bit data and the read-back address at 14. These values are small enough that four pushes reach the full boundary and a fifth push reaches overflow. They also let the release hold be counted cycle by cycle. Under these conditions the bench can observe the last cycle in which `alt_req` is still high and the first cycle in which it is low. It checks both threshold modes on both sides of each boundary.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int CFG_BITS = 5;

  // Packed MSB first: alt_en is bit 4, thr_empty is bit 0.
  typedef struct packed {
    logic alt_en;     // alternate request line in request mode
    logic wreq_en;    // wait/request line in request mode
    logic ext_rd;     // allow configuration read-back
    logic alt_fast;   // alternate line releases without hold
    logic thr_empty;  // 1: fire on completely empty, 0: on free entry slot
  } txq_cfg_t;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  count,
  output logic              ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              wr_ok, rd_ok, is_full;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full = (count == CNT_W'(DEPTH));
  assign wr_ok   = push && !is_full;
  assign rd_ok   = pop && (count != '0);

  // Storage without reset so it can map onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (clr)        pop_data <= '0;
    else if (rd_ok) pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && is_full) ovf <= 1'b1;
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (clr)
    count <= CNT_W'(DEPTH));
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (clr)
    ovf |=> ovf);
  assert_full_push_dropped_R3: assert property (@(posedge clk) disable iff (clr)
    (is_full && push && !pop) |=> (is_full && ovf));
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (clr)
    (count == '0 && pop && !push) |=> ($stable(pop_data) && count == '0));
endmodule

// File: rtl/txq_cfg.sv
module txq_cfg
  import txq_pkg::*;
(
  input  logic                clk,
  input  logic                clr,
  input  logic                we,
  input  logic [CFG_BITS-1:0] wdata,
  output txq_cfg_t            cfg_q
);
  always_ff @(posedge clk) begin
    if (clr)     cfg_q <= '0;
    else if (we) cfg_q <= txq_cfg_t'(wdata);
  end

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (clr)
    !we |=> $stable(cfg_q));
endmodule

// File: rtl/txq_req.sv
module txq_req
  import txq_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int CNT_W     = $clog2(DEPTH + 1),
  parameter int REL_DELAY = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  txq_cfg_t         cfg,
  input  logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             wreq,
  output logic             alt
);
  logic cond, alt_tgt;

  assign cond    = cfg.thr_empty ? (count == '0) : (count < CNT_W'(DEPTH));
  assign alt_tgt = cfg.alt_en && cond;

  always_ff @(posedge clk) begin
    if (clr) begin
      irq  <= 1'b0;
      wreq <= 1'b0;
    end else begin
      irq  <= cond;
      wreq <= cfg.wreq_en && cond;
    end
  end

  generate
    if (REL_DELAY > 0) begin : g_hold
      localparam int HW = $clog2(REL_DELAY + 1);
      logic [HW-1:0] hold_cnt;

      always_ff @(posedge clk) begin
        if (clr) begin
          alt      <= 1'b0;
          hold_cnt <= '0;
        end else if (alt_tgt) begin
          alt      <= 1'b1;
          hold_cnt <= '0;
        end else if (cfg.alt_fast || !alt) begin
          alt      <= 1'b0;
          hold_cnt <= '0;
        end else if (hold_cnt == HW'(REL_DELAY)) begin
          alt      <= 1'b0;
          hold_cnt <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end

      assert_hold_bound_R8: assert property (@(posedge clk) disable iff (clr)
        hold_cnt <= HW'(REL_DELAY));
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (clr) alt <= 1'b0;
        else     alt <= alt_tgt;
      end
    end
  endgenerate

  assert_wreq_under_irq_R7: assert property (@(posedge clk) disable iff (clr)
    wreq |-> irq);
  assert_fast_release_R9: assert property (@(posedge clk) disable iff (clr)
    (cfg.alt_fast && !alt_tgt) |=> !alt);
endmodule

// File: rtl/txfifo_req_gen.sv
module txfifo_req_gen
  import txq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 4,
  parameter int REL_DELAY  = 4,
  parameter int RADDR_W    = 4,
  parameter int STAT_RADDR = 0,
  parameter int CFG_RADDR  = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chan_rst,
  input  logic               push_valid,
  input  logic [DATA_W-1:0]  push_data,
  input  logic               pop_req,
  output logic [DATA_W-1:0]  pop_data,
  input  logic               cfg_we,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic [RADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq,
  output logic               wreq,
  output logic               alt_req
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clr;
  logic [CNT_W-1:0] count;
  logic             ovf;
  txq_cfg_t         cfg;
  logic [DATA_W-1:0] status_w, cfg_w;
  logic             unused_cfg_hi;

  assign clr           = rst || chan_rst;
  assign unused_cfg_hi = ^cfg_wdata[DATA_W-1:CFG_BITS];

  txq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .clr(clr), .push(push_valid), .push_data(push_data),
    .pop(pop_req), .pop_data(pop_data), .count(count), .ovf(ovf)
  );

  txq_cfg u_cfg (
    .clk(clk), .clr(clr), .we(cfg_we), .wdata(cfg_wdata[CFG_BITS-1:0]),
    .cfg_q(cfg)
  );

  txq_req #(.DEPTH(DEPTH), .CNT_W(CNT_W), .REL_DELAY(REL_DELAY)) u_req (
    .clk(clk), .clr(clr), .cfg(cfg), .count(count),
    .irq(irq), .wreq(wreq), .alt(alt_req)
  );

  always_comb begin
    status_w             = '0;
    status_w[DATA_W-1]   = ovf;
    status_w[DATA_W-2]   = (count == CNT_W'(DEPTH));
    status_w[DATA_W-3]   = (count == '0);
    status_w[CNT_W-1:0]  = count;
    cfg_w                = '0;
    cfg_w[CFG_BITS-1:0]  = cfg;
  end

  always_ff @(posedge clk) begin
    if (clr)
      rd_data <= '0;
    else if (rd_addr == RADDR_W'(STAT_RADDR))
      rd_data <= status_w;
    else if (rd_addr == RADDR_W'(CFG_RADDR))
      rd_data <= cfg.ext_rd ? cfg_w : status_w;
    else
      rd_data <= '0;
  end

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (clr)
    (rd_addr == RADDR_W'(CFG_RADDR) && cfg.ext_rd) |=> (rd_data[DATA_W-1:CFG_BITS] == '0));
  assert_other_addr_zero_R11: assert property (@(posedge clk) disable iff (clr)
    (rd_addr != RADDR_W'(CFG_RADDR) && rd_addr != RADDR_W'(STAT_RADDR)) |=> (rd_data == '0));
endmodule

// File: tb/txfifo_req_gen_tb.sv
`timescale 1ns/1ps
module txfifo_req_gen_tb;
  localparam int DW = 8, DEPTH = 4, RDLY = 4, CFGA = 14;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, chan_rst = 1'b0, push_valid = 1'b0, pop_req = 1'b0, cfg_we = 1'b0;
  logic [DW-1:0] push_data = '0, cfg_wdata = '0, pop_data, rd_data;
  logic [3:0] rd_addr = '0;
  logic irq, wreq, alt_req;

  txfifo_req_gen u_dut (
    .clk(clk), .rst(rst), .chan_rst(chan_rst), .push_valid(push_valid),
    .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .wreq(wreq), .alt_req(alt_req)
  );

  int checks = 0, failures = 0;
  logic [7:0] model_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] last_pop = '0;
  logic pop_seen = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    push_valid = 1'b1; push_data = b;
    if (model_q.size() < DEPTH) model_q.push_back(b);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pop();
    pop_req = 1'b1;
    if (model_q.size() > 0) last_pop = model_q.pop_front();
    exp_q.push_back(last_pop);
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  task automatic cfgw(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  // Scoreboard monitor: compare each delivered byte with the model.
  always @(posedge clk) pop_seen <= pop_req && !rst && !chan_rst;
  always @(negedge clk) begin
    if (pop_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk("R2 R4 pop order / empty-pop hold", pop_data, e);
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 irq after reset", irq, 1);
    chk("R1 wreq after reset", wreq, 0);
    chk("R1 alt_req after reset", alt_req, 0);
    rd(4'd0, v);    chk("R1 status after reset", v, 8'h20);
    rd(CFGA, v);    chk("R11 readback disabled gives status", v, 8'h20);
    rd(4'd3, v);    chk("R11 other address", v, 8'h00);

    // R2/R5 fill
    push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
    idle(1);
    chk("R5 irq low when full", irq, 0);
    rd(4'd0, v);    chk("R2 status full", v, 8'h44);
    push(8'hEE);
    rd(4'd0, v);    chk("R3 overflow sticky", v, 8'hC4);

    pop();
    idle(1);
    chk("R5 irq high with free slot", irq, 1);
    pop(); pop(); pop();
    pop();          // R4: empty pop repeats A4
    rd(4'd0, v);    chk("R4 empty pop leaves count and flags", v, 8'hA0);

    // R12 channel reset
    cfgw(8'h04);
    rd(CFGA, v);    chk("R11 config readback", v, 8'h04);
    chan_rst = 1'b1; idle(1); chan_rst = 1'b0;
    rd(CFGA, v);    chk("R12 chan_rst clears config", v, 8'h20);
    rd(4'd0, v);    chk("R12 chan_rst clears overflow", v, 8'h20);

    // R6 empty threshold
    cfgw(8'h01); idle(1);
    chk("R6 irq high when empty", irq, 1);
    push(8'h55); idle(1);
    chk("R6 irq low with one byte", irq, 0);
    pop(); idle(1);
    chk("R6 irq back when empty", irq, 1);

    // R7 wait/request line
    cfgw(8'h09); idle(1);
    chk("R7 wreq high when empty", wreq, 1);
    push(8'h66); idle(1);
    chk("R7 wreq follows threshold", wreq, 0);
    pop(); idle(1);
    chk("R7 wreq reasserts", wreq, 1);
    cfgw(8'h01); idle(1);
    chk("R7 wreq off when disabled", wreq, 0);

    // R8 delayed release
    cfgw(8'h18); idle(1);
    chk("R8 alt_req asserted", alt_req, 1);
    push(8'h10); push(8'h11); push(8'h12); push(8'h13);
    for (int k = 0; k <= RDLY; k++) begin
      @(negedge clk);
      if (k == 0)        chk("R8 wreq releases first", wreq, 0);
      if (k == RDLY - 1) chk("R8 alt_req still held", alt_req, 1);
      if (k == RDLY)     chk("R8 alt_req released after hold", alt_req, 0);
    end
    pop(); idle(1);
    chk("R8 alt_req reasserts at once", alt_req, 1);

    // R9 fast release
    cfgw(8'h1A); idle(1);
    push(8'h14); idle(1);
    chk("R9 wreq released", wreq, 0);
    chk("R9 alt_req released with wreq", alt_req, 0);
    pop(); pop(); pop(); pop();

    // R10/R11 reserved bits and read-back switch
    cfgw(8'hFF);
    rd(CFGA, v);    chk("R10 reserved bits read zero", v, 8'h1F);
    cfgw(8'h1B);
    rd(CFGA, v);    chk("R11 readback off returns status", v, 8'h20);

    idle(2);
    summary();
  end
endmodule